// File: doc/BRIEF.md
# Double-Buffered Schedule Fetch Memory

This block holds the gate-control schedule words for one egress port. Register-side logic writes words through a write port that always takes a full 7-bit address. The schedule sequencer reads words through a synchronous read port. The 128-word array works in one of two ways. It can be a single 128-entry table, or it can be two 64-word banks, lower and upper.

In split mode, software fills the idle bank while the sequencer walks the live one. The bank-select input is only sampled when an interval-start pulse arrives. A new schedule therefore replaces the old one exactly on an interval boundary and never in the middle of an interval. The bank in use is reported on a status output. Decoding the schedule words and stepping through the table are handled elsewhere.

Top module: `sched_fetch_mem`

## Requirements
- R1: After reset, `bank_act_o` is 0 and `rd_data_o` is 0. Because the configuration inputs are also 0 at reset, the block starts in split mode with the lower bank active.
- R2: When `one_buf_i` = 1, the read address is `rd_idx_i` taken directly as a 7-bit address, so all 128 words can be reached.
- R3: When `one_buf_i` = 0, the read address is {active bank, `rd_idx_i[5:0]`}. The active bank forms address bit 6, and `rd_idx_i[6]` has no effect.
- R4: The active-bank register loads `buf_sel_i` only on a clock edge where `interval_start_i` = 1. At every other edge it holds its value, so a change of `buf_sel_i` has no effect until the next interval start.
- R5: When `one_buf_i` = 0, `bank_act_o` shows the active bank (1 = upper, 0 = lower). When `one_buf_i` = 1, it reads 0.
- R6: A read issued with `rd_en_i` = 1 returns its word on `rd_data_o` after the next clock edge. While `rd_en_i` = 0, `rd_data_o` keeps its value.
- R7: Writes with `wr_en_i` = 1 store `wr_data_i` at the absolute 7-bit `wr_addr_i`. This holds in both modes and whichever bank is active, so the idle bank can be written while the other bank is being read.
- R8: If a write and a read hit the same address in the same cycle, the read returns the data held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| one_buf_i | input | 1 | 1 = single 128-word table, 0 = two 64-word banks |
| buf_sel_i | input | 1 | Requested bank in split mode (1 = upper) |
| interval_start_i | input | 1 | One-cycle pulse that marks the start of a schedule interval |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 7 | Absolute write address |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_idx_i | input | 7 | Sequencer read index |
| rd_data_o | output | 32 | Read data, one cycle after the read |
| bank_act_o | output | 1 | Bank currently in use |

## Verification
Every word holds a value derived from its own address, so each read shows which physical word was selected. In single-table mode, indices on both sides of 64 are read. This separates direct 7-bit addressing from bank-relative addressing. In split mode, the same index is read with bit 6 set and with it clear, and again after each bank change. This shows that index bit 6 is ignored and that the bank bit drives the address. The bank-select input is changed several cycles before the interval pulse, so a switch that happens too early is caught. The bench also covers a same-address write and read in one cycle, and a write to the idle bank followed by a switch to it.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  localparam int unsigned SFM_DEPTH = 128;
  localparam int unsigned SFM_DW    = 32;
  localparam int unsigned SFM_AW    = $clog2(SFM_DEPTH);
endpackage

// File: rtl/sfm_bank_ctrl.sv
module sfm_bank_ctrl #(
  parameter int unsigned AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          one_buf_i,
  input  logic          buf_sel_i,
  input  logic          interval_start_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          bank_act_o
);
  logic bank_q;

  // select is sampled only on interval boundaries
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               bank_q <= 1'b0;
    else if (interval_start_i) bank_q <= buf_sel_i;
  end

  always_comb begin
    if (one_buf_i) rd_addr_o = rd_idx_i;
    else           rd_addr_o = {bank_q, rd_idx_i[AW-2:0]};
  end

  assign bank_act_o = bank_q & ~one_buf_i;

  p_bank_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    interval_start_i |=> bank_q == $past(buf_sel_i));
  p_bank_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !interval_start_i |=> $stable(bank_q));
  p_status_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    one_buf_i |-> !bank_act_o);
endmodule

// File: rtl/sfm_ram.sv
module sfm_ram #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  // read-before-write on a same-address collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= mem_q[rd_addr_i];
  end

  p_rd_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/sched_fetch_mem.sv
module sched_fetch_mem
  import sfm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              one_buf_i,
  input  logic              buf_sel_i,
  input  logic              interval_start_i,
  input  logic              wr_en_i,
  input  logic [SFM_AW-1:0] wr_addr_i,
  input  logic [SFM_DW-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [SFM_AW-1:0] rd_idx_i,
  output logic [SFM_DW-1:0] rd_data_o,
  output logic              bank_act_o
);
  logic [SFM_AW-1:0] rd_addr;

  sfm_bank_ctrl #(.AW(SFM_AW)) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .one_buf_i       (one_buf_i),
    .buf_sel_i       (buf_sel_i),
    .interval_start_i(interval_start_i),
    .rd_idx_i        (rd_idx_i),
    .rd_addr_o       (rd_addr),
    .bank_act_o      (bank_act_o)
  );

  sfm_ram #(.DEPTH(SFM_DEPTH), .DW(SFM_DW)) u_ram (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .rd_en_i  (rd_en_i),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data_o)
  );
endmodule

// File: tb/sched_fetch_mem_tb.sv
module sched_fetch_mem_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        one_buf, buf_sel, istart, wr_en, rd_en;
  logic [6:0]  wr_addr, rd_idx;
  logic [31:0] wr_data, rd_data;
  logic        bank_act;
  int          errors = 0;
  int          checks = 0;

  always #10 clk = ~clk;

  sched_fetch_mem u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .one_buf_i(one_buf), .buf_sel_i(buf_sel),
    .interval_start_i(istart), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_idx_i(rd_idx),
    .rd_data_o(rd_data), .bank_act_o(bank_act)
  );

  function automatic logic [31:0] pat(int a);
    return 32'h5A00_0000 + 32'(a * 3 + 1);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = 7'(a); wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(int idx, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; rd_idx = 7'(idx);
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic pulse_start();
    @(negedge clk); istart = 1'b1;
    @(negedge clk); istart = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 status", 32'(bank_act), 32'd0);
    chk("R1 rdata", rd_data, 32'd0);
  endtask

  task automatic t_one_buf();
    logic [31:0] d;
    one_buf = 1'b1;
    for (int a = 0; a < 128; a++) wr(a, pat(a));
    rd(0, d);   chk("R2/R7 idx0", d, pat(0));
    rd(70, d);  chk("R2/R7 idx70", d, pat(70));
    rd(127, d); chk("R2 idx127", d, pat(127));
    chk("R5 status one-buf", 32'(bank_act), 32'd0);
  endtask

  task automatic t_split_lower();
    logic [31:0] d;
    @(negedge clk); one_buf = 1'b0;
    rd(5, d);  chk("R3 lower idx5", d, pat(5));
    rd(69, d); chk("R3 lower idx bit6 ignored", d, pat(5));
    chk("R5 status lower", 32'(bank_act), 32'd0);
  endtask

  task automatic t_deferred_switch();
    logic [31:0] d;
    @(negedge clk); buf_sel = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 no early switch status", 32'(bank_act), 32'd0);
    rd(5, d); chk("R4 no early switch read", d, pat(5));
    pulse_start();
    chk("R4/R5 status upper", 32'(bank_act), 32'd1);
    rd(5, d);  chk("R3 upper idx5", d, pat(69));
    rd(69, d); chk("R3 upper idx69", d, pat(69));
  endtask

  task automatic t_one_buf_masks();
    logic [31:0] d;
    @(negedge clk); one_buf = 1'b1;
    @(negedge clk);
    chk("R5 status masked", 32'(bank_act), 32'd0);
    rd(5, d); chk("R2 direct idx5", d, pat(5));
  endtask

  task automatic t_hold();
    logic [31:0] d;
    rd(33, d);
    @(negedge clk); rd_idx = 7'd90; wr_en = 1'b1; wr_addr = 7'd40; wr_data = pat(40);
    @(negedge clk); wr_en = 1'b0;
    chk("R6 hold without rd_en", rd_data, pat(33));
  endtask

  task automatic t_collision();
    logic [31:0] d;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 7'd10; wr_data = 32'hDEAD_BEEF;
    rd_en = 1'b1; rd_idx = 7'd10;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    chk("R8 old data on collision", rd_data, pat(10));
    rd(10, d); chk("R8 new data next read", d, 32'hDEAD_BEEF);
  endtask

  task automatic t_idle_bank_write();
    logic [31:0] d;
    @(negedge clk); one_buf = 1'b0;
    wr(3, 32'h0BAD_F00D);
    rd(3, d); chk("R7 live upper unaffected", d, pat(67));
    @(negedge clk); buf_sel = 1'b0;
    pulse_start();
    chk("R4 status back to lower", 32'(bank_act), 32'd0);
    rd(3, d); chk("R7 idle-bank write visible", d, 32'h0BAD_F00D);
  endtask

  initial begin
    one_buf = 1'b0; buf_sel = 1'b0; istart = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_addr = '0; rd_idx = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    fork
      begin
        t_one_buf();
        t_split_lower();
        t_deferred_switch();
        t_one_buf_masks();
        t_hold();
        t_collision();
        t_idle_bank_write();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule